// File: doc/BRIEF.md
# Exception entry and vectoring unit

This block controls exception entry for a small 32-bit processor core. Seven request lines come in: reset request, undefined instruction, trap (software interrupt), prefetch abort, data abort, normal interrupt and fast interrupt. The two interrupt lines are gated by mask bits in the current status word, and they are also gated by a flag that says the instruction in the execute stage has finished. When at least one request is eligible, the unit picks a single winner by fixed priority. It then runs a four-phase entry sequence:

1. It switches the mode field.
2. It stores the previous status into the saved-status bank that belongs to the new mode.
3. It strobes a link-register write for the new mode.
4. It sets the interrupt mask bits and presents the vector fetch address.

The unit holds the current status word and one saved-status register for each exception mode. Software loads the status word through a write port while the unit is idle. An exception-return strobe copies the saved status of the current mode back into the current status in one cycle. The link-register file itself sits outside the block. This unit only drives its write enable, target mode and data.

Top module: `exc_entry_unit`

## Requirements
- R1: After `rst_n` is low, `status_q` is 0x000000D3 (supervisor mode 0x13 in bits 4:0, both mask bits 7 and 6 set), and `busy`, `save_we`, `link_we` and `vec_valid` are all 0.
- R2: A normal interrupt is accepted only when status bit 7 is 0 and `ex_done` is 1. A fast interrupt is accepted only when status bit 6 is 0 and `ex_done` is 1. The other five sources do not depend on the mask bits or on `ex_done`.
- R3: When several eligible requests are present in the same cycle, exactly one is served, in this priority order from highest: reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction, trap. `exc_src` reports the winner's code: reset 0, undefined 1, trap 2, prefetch abort 3, data abort 4, normal interrupt 6, fast interrupt 7.
- R4: The new mode is 0x13 for reset and trap, 0x1B for undefined, 0x17 for either abort, 0x12 for a normal interrupt and 0x11 for a fast interrupt. `save_mode` and `link_mode` carry this value.
- R5: `vec_addr` equals the base plus 4 times the source code. The base is 0x00000000 when `hi_vec` is 0 and 0xFFFF0000 when `hi_vec` is 1.
- R6: Number the acceptance clock edge as edge 0. After edge 1, the mode field holds the new mode and `save_we` is high. After edge 2, `link_we` is high. After edge 3, `vec_valid` is high. After edge 4, `busy` is low. `busy` is high from edge 0 until edge 4.
- R7: `link_data` equals `resume_pc` plus an offset: 4 for either interrupt and for prefetch abort, 8 for data abort, and 0 for reset, undefined and trap. A normal-interrupt handler therefore subtracts 4 to get the resume address.
- R8: At the end of entry, status bit 7 is set. Bit 6 is also set for a fast interrupt and is otherwise kept. All bits above 7, and bit 5, keep their previous values.
- R9: While the unit is idle and in a mode that has a saved-status bank (0x11, 0x12, 0x13, 0x17, 0x1B), `exc_ret` makes `status_q` equal to that bank's contents after one clock edge.
- R10: `exc_ret` in user mode (0x10) or system mode (0x1F) leaves `status_q` unchanged.
- R11: While `busy` is high, new requests, status writes and return strobes have no effect. The final status is exactly the value given by R8.
- R12: While idle, with no eligible request and `st_wr_en` high, `status_q` loads `st_wr_data` after one edge. If a request is accepted in that cycle, the status write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hi_vec | input | 1 | Selects the high vector base |
| ex_done | input | 1 | Execute-stage instruction has completed |
| req_reset | input | 1 | Reset exception request |
| req_undef | input | 1 | Undefined instruction request |
| req_trap | input | 1 | Software interrupt (trap) request |
| req_pabt | input | 1 | Prefetch abort request |
| req_dabt | input | 1 | Data abort request |
| irq_req | input | 1 | Normal interrupt request |
| fiq_req | input | 1 | Fast interrupt request |
| resume_pc | input | 32 | Address where execution would resume |
| st_wr_en | input | 1 | Status write strobe |
| st_wr_data | input | 32 | Status write value |
| exc_ret | input | 1 | Exception-return strobe |
| status_q | output | 32 | Current status word |
| busy | output | 1 | Entry sequence in progress |
| exc_src | output | 3 | Code of the source being served |
| save_we | output | 1 | Saved-status write phase |
| save_mode | output | 5 | Bank mode for the saved-status write |
| link_we | output | 1 | Link-register write enable |
| link_mode | output | 5 | Bank mode for the link write |
| link_data | output | 32 | Link value |
| vec_valid | output | 1 | Vector address valid |
| vec_addr | output | 32 | Vector fetch address |

## Verification
The bench builds the block with its defaults: 32-bit addresses and status word, mask bits at positions 7 and 6, and the base selected at run time by the pin. It then sweeps all 1024 combinations of the seven requests, the two mask bits and `ex_done`, and alternates `hi_vec` across the sweep. This covers every priority contention, every masking case and every source reaching each bank and both vector bases. Each accepted entry is followed by two return strobes. The first restores the status through the bank, which exercises both the save and the restore paths. The second, now issued in user mode, must change nothing.

// File: rtl/exc_pkg.sv
package exc_pkg;

   typedef enum logic [2:0] {
      SRC_RESET = 3'd0,
      SRC_UNDEF = 3'd1,
      SRC_TRAP  = 3'd2,
      SRC_PABT  = 3'd3,
      SRC_DABT  = 3'd4,
      SRC_RSVD  = 3'd5,
      SRC_IRQ   = 3'd6,
      SRC_FIQ   = 3'd7
   } src_e;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_MODE,
      PH_SAVE,
      PH_LINK,
      PH_MASK
   } phase_e;

   localparam int MODE_W = 5;
   localparam int NSRC   = 8;
   localparam int NBANK  = 5;

   localparam logic [MODE_W-1:0] MD_USER = 5'h10;
   localparam logic [MODE_W-1:0] MD_FAST = 5'h11;
   localparam logic [MODE_W-1:0] MD_IRQ  = 5'h12;
   localparam logic [MODE_W-1:0] MD_SUPV = 5'h13;
   localparam logic [MODE_W-1:0] MD_ABRT = 5'h17;
   localparam logic [MODE_W-1:0] MD_UNDF = 5'h1B;
   localparam logic [MODE_W-1:0] MD_SYS  = 5'h1F;

   localparam logic [MODE_W-1:0] BANK_MODE [NBANK] =
      '{MD_FAST, MD_IRQ, MD_SUPV, MD_ABRT, MD_UNDF};

   // Served order, highest priority first
   localparam src_e SERVE_ORDER [7] =
      '{SRC_RESET, SRC_DABT, SRC_FIQ, SRC_IRQ, SRC_PABT, SRC_UNDEF, SRC_TRAP};

   function automatic logic [MODE_W-1:0] mode_of(input src_e s);
      case (s)
         SRC_RESET, SRC_TRAP : return MD_SUPV;
         SRC_UNDEF           : return MD_UNDF;
         SRC_PABT, SRC_DABT  : return MD_ABRT;
         SRC_IRQ             : return MD_IRQ;
         SRC_FIQ             : return MD_FAST;
         default             : return MD_SUPV;
      endcase
   endfunction

   // Returns NBANK when the mode owns no saved-status register
   function automatic logic [2:0] bank_of(input logic [MODE_W-1:0] m);
      logic [2:0] idx;
      idx = 3'(NBANK);
      for (int i = 0; i < NBANK; i++)
         if (BANK_MODE[i] == m) idx = 3'(i);
      return idx;
   endfunction

   function automatic logic [3:0] link_adj(input src_e s);
      case (s)
         SRC_IRQ, SRC_FIQ, SRC_PABT : return 4'd4;
         SRC_DABT                   : return 4'd8;
         default                    : return 4'd0;
      endcase
   endfunction

endpackage

// File: rtl/exc_prio_sel.sv
module exc_prio_sel
   import exc_pkg::*;
(
   input  logic [NSRC-1:0] req,
   input  logic            irq_blk,
   input  logic            fiq_blk,
   input  logic            ex_done,
   input  logic            enable,
   output logic            take,
   output src_e            src
);

   logic [NSRC-1:0] keep;
   logic [NSRC-1:0] elig;

   always_comb begin
      keep           = '1;
      keep[SRC_RSVD] = 1'b0;
      keep[SRC_IRQ]  = ~irq_blk & ex_done;
      keep[SRC_FIQ]  = ~fiq_blk & ex_done;
      elig           = req & keep & {NSRC{enable}};
   end

   // Walk from lowest to highest priority so the highest one wins
   always_comb begin
      take = 1'b0;
      src  = SRC_RESET;
      for (int i = 6; i >= 0; i--) begin
         if (elig[SERVE_ORDER[i]]) begin
            take = 1'b1;
            src  = SERVE_ORDER[i];
         end
      end
   end

endmodule

// File: rtl/exc_vec_gen.sv
module exc_vec_gen
   import exc_pkg::*;
#(
   parameter int                ADDR_W    = 32,
   parameter logic [ADDR_W-1:0] LOW_BASE  = '0,
   parameter logic [ADDR_W-1:0] HIGH_BASE = 32'hFFFF_0000,
   parameter int                BASE_SEL  = 0
)(
   input  logic              hi_sel,
   input  src_e              src,
   output logic [ADDR_W-1:0] addr
);

   localparam int OFS_W = $bits(src_e) + 2;

   logic [ADDR_W-1:0] base;
   logic [OFS_W-1:0]  ofs;

   generate
      if (BASE_SEL == 0) begin : g_pin_base
         assign base = hi_sel ? HIGH_BASE : LOW_BASE;
      end else if (BASE_SEL == 1) begin : g_low_base
         assign base = LOW_BASE;
      end else begin : g_high_base
         assign base = HIGH_BASE;
      end
   endgenerate

   assign ofs  = {src, 2'b00};
   assign addr = base + ADDR_W'(ofs);

endmodule

// File: rtl/exc_status_bank.sv
module exc_status_bank
   import exc_pkg::*;
#(
   parameter int                STAT_W   = 32,
   parameter logic [STAT_W-1:0] STAT_RST = 32'h0000_00D3
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cur_wr_en,
   input  logic [STAT_W-1:0] cur_wr_data,
   input  logic              mode_wr_en,
   input  logic [MODE_W-1:0] mode_wr_val,
   input  logic              save_en,
   input  logic [MODE_W-1:0] save_mode,
   input  logic [STAT_W-1:0] save_data,
   input  logic              mask_en,
   input  logic [STAT_W-1:0] mask_bits,
   input  logic              restore_en,
   output logic [STAT_W-1:0] status_q
);

   logic [STAT_W-1:0] bank_q [NBANK];
   logic [2:0]        cur_bank;
   logic              cur_banked;

   generate
      for (genvar b = 0; b < NBANK; b++) begin : g_bank
         always_ff @(posedge clk) begin
            if (!rst_n)
               bank_q[b] <= '0;
            else if (save_en && save_mode == BANK_MODE[b])
               bank_q[b] <= save_data;
         end
      end
   endgenerate

   assign cur_bank   = bank_of(status_q[MODE_W-1:0]);
   assign cur_banked = (cur_bank < 3'(NBANK));

   always_ff @(posedge clk) begin
      if (!rst_n)
         status_q <= STAT_RST;
      else if (restore_en) begin
         if (cur_banked)
            status_q <= bank_q[cur_bank];
      end
      else if (cur_wr_en)
         status_q <= cur_wr_data;
      else if (mode_wr_en)
         status_q[MODE_W-1:0] <= mode_wr_val;
      else if (mask_en)
         status_q <= status_q | mask_bits;
   end

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
   import exc_pkg::*;
#(
   parameter int                ADDR_W    = 32,
   parameter int                STAT_W    = 32,
   parameter int                IRQ_BIT   = 7,
   parameter int                FIQ_BIT   = 6,
   parameter int                BASE_SEL  = 0,
   parameter logic [ADDR_W-1:0] LOW_BASE  = '0,
   parameter logic [ADDR_W-1:0] HIGH_BASE = 32'hFFFF_0000
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hi_vec,
   input  logic              ex_done,
   input  logic              req_reset,
   input  logic              req_undef,
   input  logic              req_trap,
   input  logic              req_pabt,
   input  logic              req_dabt,
   input  logic              irq_req,
   input  logic              fiq_req,
   input  logic [ADDR_W-1:0] resume_pc,
   input  logic              st_wr_en,
   input  logic [STAT_W-1:0] st_wr_data,
   input  logic              exc_ret,
   output logic [STAT_W-1:0] status_q,
   output logic              busy,
   output logic [2:0]        exc_src,
   output logic              save_we,
   output logic [MODE_W-1:0] save_mode,
   output logic              link_we,
   output logic [MODE_W-1:0] link_mode,
   output logic [ADDR_W-1:0] link_data,
   output logic              vec_valid,
   output logic [ADDR_W-1:0] vec_addr
);

   localparam logic [STAT_W-1:0] IRQ_MASK = STAT_W'(1) << IRQ_BIT;
   localparam logic [STAT_W-1:0] FIQ_MASK = STAT_W'(1) << FIQ_BIT;
   localparam logic [STAT_W-1:0] STAT_RST = IRQ_MASK | FIQ_MASK | STAT_W'(MD_SUPV);

   generate
      if (ADDR_W < 8) begin : g_chk_addr
         $error("exc_entry_unit: ADDR_W must be at least 8");
      end
      if (STAT_W < 8) begin : g_chk_stat
         $error("exc_entry_unit: STAT_W must be at least 8");
      end
      if (IRQ_BIT == FIQ_BIT || IRQ_BIT < MODE_W || FIQ_BIT < MODE_W ||
          IRQ_BIT >= STAT_W || FIQ_BIT >= STAT_W) begin : g_chk_bits
         $error("exc_entry_unit: mask bit positions invalid");
      end
      if (BASE_SEL < 0 || BASE_SEL > 2) begin : g_chk_base
         $error("exc_entry_unit: BASE_SEL must be 0, 1 or 2");
      end
   endgenerate

   phase_e            ph_q;
   src_e              src_q;
   src_e              win_src;
   logic              win_take;
   logic              idle;
   logic [STAT_W-1:0] old_st_q;
   logic [ADDR_W-1:0] link_q;
   logic [NSRC-1:0]   req_vec;
   logic [MODE_W-1:0] new_mode;
   logic [STAT_W-1:0] mask_bits;

   assign idle = (ph_q == PH_IDLE);

   always_comb begin
      req_vec            = '0;
      req_vec[SRC_RESET] = req_reset;
      req_vec[SRC_UNDEF] = req_undef;
      req_vec[SRC_TRAP]  = req_trap;
      req_vec[SRC_PABT]  = req_pabt;
      req_vec[SRC_DABT]  = req_dabt;
      req_vec[SRC_IRQ]   = irq_req;
      req_vec[SRC_FIQ]   = fiq_req;
   end

   exc_prio_sel u_prio (
      .req     (req_vec),
      .irq_blk (status_q[IRQ_BIT]),
      .fiq_blk (status_q[FIQ_BIT]),
      .ex_done (ex_done),
      .enable  (idle),
      .take    (win_take),
      .src     (win_src)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q     <= PH_IDLE;
         src_q    <= SRC_RESET;
         old_st_q <= '0;
         link_q   <= '0;
      end else begin
         case (ph_q)
            PH_IDLE: if (win_take) begin
               ph_q     <= PH_MODE;
               src_q    <= win_src;
               old_st_q <= status_q;
               link_q   <= resume_pc + ADDR_W'(link_adj(win_src));
            end
            PH_MODE: ph_q <= PH_SAVE;
            PH_SAVE: ph_q <= PH_LINK;
            PH_LINK: ph_q <= PH_MASK;
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign new_mode  = mode_of(src_q);
   assign mask_bits = (src_q == SRC_FIQ) ? (IRQ_MASK | FIQ_MASK) : IRQ_MASK;

   exc_status_bank #(
      .STAT_W   (STAT_W),
      .STAT_RST (STAT_RST)
   ) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .cur_wr_en   (idle && !win_take && st_wr_en),
      .cur_wr_data (st_wr_data),
      .mode_wr_en  (ph_q == PH_MODE),
      .mode_wr_val (new_mode),
      .save_en     (ph_q == PH_SAVE),
      .save_mode   (new_mode),
      .save_data   (old_st_q),
      .mask_en     (ph_q == PH_MASK),
      .mask_bits   (mask_bits),
      .restore_en  (idle && !win_take && !st_wr_en && exc_ret),
      .status_q    (status_q)
   );

   exc_vec_gen #(
      .ADDR_W    (ADDR_W),
      .LOW_BASE  (LOW_BASE),
      .HIGH_BASE (HIGH_BASE),
      .BASE_SEL  (BASE_SEL)
   ) u_vec (
      .hi_sel (hi_vec),
      .src    (src_q),
      .addr   (vec_addr)
   );

   assign busy      = !idle;
   assign exc_src   = src_q;
   assign save_we   = (ph_q == PH_SAVE);
   assign save_mode = new_mode;
   assign link_we   = (ph_q == PH_LINK);
   assign link_mode = new_mode;
   assign link_data = link_q;
   assign vec_valid = (ph_q == PH_MASK);

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
   parameter int ADDR_W  = 32,
   parameter int STAT_W  = 32,
   parameter int IRQ_BIT = 7,
   parameter int FIQ_BIT = 6
)(
   input logic              clk,
   input logic              rst_n,
   input logic [STAT_W-1:0] status_q,
   input logic              busy,
   input logic [2:0]        exc_src,
   input logic              save_we,
   input logic [4:0]        save_mode,
   input logic              link_we,
   input logic [4:0]        link_mode,
   input logic              vec_valid,
   input logic [ADDR_W-1:0] vec_addr
);

   assert_mode_before_save_R6: assert property (@(posedge clk) disable iff (!rst_n)
      save_we |-> status_q[4:0] == save_mode);

   assert_save_then_link_R6: assert property (@(posedge clk) disable iff (!rst_n)
      save_we |=> link_we);

   assert_link_then_vec_R6: assert property (@(posedge clk) disable iff (!rst_n)
      link_we |=> vec_valid);

   assert_vec_then_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |=> !busy);

   assert_strobes_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({save_we, link_we, vec_valid}));

   assert_irq_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy) && exc_src == 3'd6) |-> !$past(status_q[IRQ_BIT]));

   assert_fiq_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy) && exc_src == 3'd7) |-> !$past(status_q[FIQ_BIT]));

   assert_irq_bit_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |=> status_q[IRQ_BIT]);

   assert_link_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
      link_we |-> link_mode == status_q[4:0]);

   assert_vec_offset_R5: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> (vec_addr[4:2] == exc_src && vec_addr[1:0] == 2'b00));

   assert_busy_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !vec_valid) |=> busy);

   assert_src_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(exc_src));

endmodule

bind exc_entry_unit exc_entry_chk #(
   .ADDR_W  (ADDR_W),
   .STAT_W  (STAT_W),
   .IRQ_BIT (IRQ_BIT),
   .FIQ_BIT (FIQ_BIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .status_q  (status_q),
   .busy      (busy),
   .exc_src   (exc_src),
   .save_we   (save_we),
   .save_mode (save_mode),
   .link_we   (link_we),
   .link_mode (link_mode),
   .vec_valid (vec_valid),
   .vec_addr  (vec_addr)
);

// File: tb/sim_exc_entry_unit.sv
module sim_exc_entry_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hi_vec = 1'b0;
   logic        ex_done = 1'b0;
   logic        req_reset = 1'b0, req_undef = 1'b0, req_trap = 1'b0;
   logic        req_pabt = 1'b0, req_dabt = 1'b0, irq_req = 1'b0, fiq_req = 1'b0;
   logic [31:0] resume_pc = '0;
   logic        st_wr_en = 1'b0;
   logic [31:0] st_wr_data = '0;
   logic        exc_ret = 1'b0;
   logic [31:0] status_q;
   logic        busy;
   logic [2:0]  exc_src;
   logic        save_we;
   logic [4:0]  save_mode;
   logic        link_we;
   logic [4:0]  link_mode;
   logic [31:0] link_data;
   logic        vec_valid;
   logic [31:0] vec_addr;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   exc_entry_unit u0 (
      .clk(clk), .rst_n(rst_n), .hi_vec(hi_vec), .ex_done(ex_done),
      .req_reset(req_reset), .req_undef(req_undef), .req_trap(req_trap),
      .req_pabt(req_pabt), .req_dabt(req_dabt), .irq_req(irq_req),
      .fiq_req(fiq_req), .resume_pc(resume_pc), .st_wr_en(st_wr_en),
      .st_wr_data(st_wr_data), .exc_ret(exc_ret), .status_q(status_q),
      .busy(busy), .exc_src(exc_src), .save_we(save_we), .save_mode(save_mode),
      .link_we(link_we), .link_mode(link_mode), .link_data(link_data),
      .vec_valid(vec_valid), .vec_addr(vec_addr)
   );

   task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   // Priority order from highest, as source codes
   function automatic int winner(input logic [7:0] r, input bit m7, input bit m6,
                                 input bit exd);
      int ord [7] = '{0, 4, 7, 6, 3, 1, 2};
      logic [7:0] e;
      e = r;
      e[6] = r[6] & !m7 & exd;
      e[7] = r[7] & !m6 & exd;
      for (int i = 0; i < 7; i++)
         if (e[ord[i]]) return ord[i];
      return -1;
   endfunction

   function automatic logic [4:0] exp_mode(input int s);
      case (s)
         0, 2: return 5'h13;
         1: return 5'h1B;
         3, 4: return 5'h17;
         6: return 5'h12;
         default: return 5'h11;
      endcase
   endfunction

   function automatic logic [31:0] exp_adj(input int s);
      case (s)
         3, 6, 7: return 32'd4;
         4: return 32'd8;
         default: return 32'd0;
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(status_q == 32'hD3, "R1 status", status_q, 32'hD3);
      chk({busy, save_we, link_we, vec_valid} == 4'b0, "R1 strobes",
          {28'd0, busy, save_we, link_we, vec_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(status_q == 32'hD3, "R1 status held", status_q, 32'hD3);

      for (int c = 0; c < 1024; c++) begin
         logic [7:0]  r;
         logic [31:0] w, pc, exp_st, base;
         bit          m7, m6, exd, hv;
         int          s;
         logic [4:0]  md;
         r   = {c[6], c[5], 1'b0, c[4:0]};
         m7  = c[7];
         m6  = c[8];
         exd = c[9];
         hv  = c[3] ^ c[9];
         w   = {16'hA500 ^ 16'(c), 8'h5C, m7, m6, 1'b0, 5'h10};
         pc  = 32'h0000_1000 + 32'(c) * 32'd16;
         s   = winner(r, m7, m6, exd);

         // R12: status write while idle
         st_wr_en = 1'b1; st_wr_data = w;
         @(negedge clk);
         st_wr_en = 1'b0;
         chk(status_q == w, "R12 status write", status_q, w);

         {fiq_req, irq_req} = r[7:6];
         {req_dabt, req_pabt, req_trap, req_undef, req_reset} = r[4:0];
         ex_done = exd; hi_vec = hv; resume_pc = pc;
         @(negedge clk);
         {fiq_req, irq_req, req_dabt, req_pabt, req_trap, req_undef, req_reset} = '0;

         if (s < 0) begin
            // R2: masked or not-ready interrupts are not taken
            chk(busy == 1'b0, "R2 no entry", {31'd0, busy}, 32'd0);
            chk(status_q == w, "R2 status kept", status_q, w);
            continue;
         end
         md = exp_mode(s);
         chk(busy == 1'b1, "R6 busy", {31'd0, busy}, 32'd1);
         chk(status_q == w, "R6 mode not yet changed", status_q, w);
         // R11: junk during busy
         st_wr_en = 1'b1; st_wr_data = 32'hFFFF_FFFF; req_reset = 1'b1; exc_ret = 1'b1;
         @(negedge clk);
         chk(status_q[4:0] == md, "R4 mode", {27'd0, status_q[4:0]}, {27'd0, md});
         chk(save_we && save_mode == md, "R6 save phase",
             {26'd0, save_we, save_mode}, {26'd0, 1'b1, md});
         @(negedge clk);
         chk(link_we && link_mode == md, "R6 link phase",
             {26'd0, link_we, link_mode}, {26'd0, 1'b1, md});
         chk(link_data == pc + exp_adj(s), "R7 link value", link_data, pc + exp_adj(s));
         @(negedge clk);
         st_wr_en = 1'b0; req_reset = 1'b0; exc_ret = 1'b0;
         base = hv ? 32'hFFFF_0000 : 32'h0;
         chk(vec_valid == 1'b1, "R6 vector phase", {31'd0, vec_valid}, 32'd1);
         chk(vec_addr == base + 32'(s) * 4, "R5 vector", vec_addr, base + 32'(s) * 4);
         chk(exc_src == 3'(s), "R3 winner", {29'd0, exc_src}, 32'(s));
         @(negedge clk);
         exp_st = {w[31:8], 1'b1, w[6] | (s == 7), w[5], md};
         chk(busy == 1'b0, "R6 idle after entry", {31'd0, busy}, 32'd0);
         chk(status_q == exp_st, "R8 R11 final status", status_q, exp_st);
         exc_ret = 1'b1;
         @(negedge clk);
         chk(status_q == w, "R9 restore", status_q, w);
         @(negedge clk);
         exc_ret = 1'b0;
         chk(status_q == w, "R10 return in user mode", status_q, w);
      end

      // R10: system mode return ignored
      st_wr_en = 1'b1; st_wr_data = 32'h0000_00DF;
      @(negedge clk);
      st_wr_en = 1'b0; exc_ret = 1'b1;
      @(negedge clk);
      exc_ret = 1'b0;
      chk(status_q == 32'hDF, "R10 system mode", status_q, 32'hDF);

      // R12: write dropped when a request is accepted
      st_wr_en = 1'b1; st_wr_data = 32'h1234_5610; req_trap = 1'b1;
      @(negedge clk);
      st_wr_en = 1'b0; req_trap = 1'b0;
      chk(status_q == 32'hDF && busy, "R12 write dropped", status_q, 32'hDF);
      repeat (5) @(negedge clk);
      finish_run();
   end

endmodule